// File: doc/BRIEF.md
# Time-Slotted Memory Bus Arbiter

This block shares one memory address bus among three requesters: two compute units (IDs 0 and 1) and one I/O processor (ID 2). It does not arbitrate by priority. A free-running slot counter steps once per clock through eight slots, and a fixed table gives each slot to one requester. A requester reaches the bus only in its own slots. When the owner of a slot has nothing to issue, the slot stays empty.

The memory behind the bus is split into interleaved banks, chosen by the upper address bits. Each bank stays occupied for a fixed number of clocks after it is selected, while its select, destructive read and rewrite complete. Accesses to different banks overlap, so three requests aimed at three banks can all start within one rotation. The arbiter keeps a busy timer for each bank and a pending-write record for each bank. A requester whose slot would hit an occupied bank, or would read a location whose write is still in progress, sees ready held low. The request is tried again in that requester's next owned slot.

A requester holds its request (valid, write flag, address) steady until it sees ready high at a clock edge. The accepted access is issued to the memory in that same cycle as a one-cycle bank strobe together with the address, write flag and owner ID. Bank storage and data paths are handled elsewhere.

Top module: `slot_bus_arbiter`

## Requirements
- R1: While reset is low at a clock edge, the slot counter returns to slot 0 and every bank timer and pending write is cleared. With no request present, ready and all bank strobes stay low.
- R2: The slot advances by one each clock and wraps from 7 to 0. The default owner table for slots 0..7 is 0,1,2,0,1,0,1,2. Ready rises only for the owner of the current slot, in the same cycle as that slot.
- R3: In a granted cycle, exactly one bank strobe is high. Its bank is address bits [11:9]. In that same cycle mem_addr, mem_write and mem_owner equal the owner's address, write flag and ID. In every other cycle no strobe is high.
- R4: A slot whose owner has no valid request grants nothing, even if other requesters are waiting.
- R5: A bank selected in cycle t refuses selection in cycles t+1 through t+11 and accepts it again from t+12 (12 clocks busy).
- R6: Accesses to different banks overlap. Right after reset, requests from IDs 0, 1 and 2 to three distinct idle banks are all granted within the first three cycles (slots 0, 1, 2).
- R7: After a write to address A is selected in cycle t, a read of A is refused through cycle t+15 (16 clocks to write completion), even once the bank timer has expired. A read of another address in the same bank is accepted from t+12.
- R8: While a write to a bank is still completing (cycles t+1 to t+15 after its select), a further write to that bank is refused.
- R9: A refused request gets ready low and no strobe. It is granted in the first later slot of the same owner in which none of R5, R7 or R8 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one clock per half time unit (one slot) |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 3 | Per-requester request valid |
| req_write | input | 3 | Per-requester write flag (1 = write, 0 = read) |
| req_addr | input | 36 | Per-requester address, 12 bits each; requester r at bits [12r+11:12r] |
| req_ready | output | 3 | Per-requester acceptance, high in the granted cycle |
| bank_sel | output | 8 | Per-bank one-cycle select strobe |
| mem_addr | output | 12 | Address of the issued access, zero when idle |
| mem_write | output | 1 | Write flag of the issued access |
| mem_owner | output | 2 | ID of the requester that owns the issued access |

## Verification
If the slot counter drifts, the grant pattern is off by one position from the fixed table from that cycle on. The bench compares every cycle, so it sees this within one rotation of eight clocks. A bank timer that expires early or late shows up as a strobe one cycle too soon, or as a retry that is still refused. A lost or wrong pending-write address shows up as a read of the written location being granted before clock 16, or as an unrelated read being held back. The bench recomputes the slot, the timers and the pending writes behaviourally. It compares ready, the strobes and the bus fields in every cycle, so a divergence is reported in the cycle where it first reaches the ports.

// File: rtl/slot_arb_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the time-slotted arbiter.
// Assumes: nothing beyond IEEE 1800-2017.
package slot_arb_pkg;

    // What happened to the current slot.
    typedef enum logic [1:0] {
        SLOT_IDLE   = 2'd0,   // owner had no request
        SLOT_GRANT  = 2'd1,   // access issued
        SLOT_BUSY   = 2'd2,   // target bank still mid-cycle
        SLOT_WRHOLD = 2'd3    // blocked by an unfinished write
    } slot_outcome_e;

    // Width helper: at least one bit.
    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/slot_sequencer.sv
`timescale 1ns/1ps
// slot_sequencer
// Steps a slot counter once per clock, wrapping after NSLOT, and looks up the
// owner of the current slot in a static table (one byte per slot, slot 0 in
// the low byte). Assumes: the table holds IDs; an ID >= NREQ never owns the bus.
module slot_sequencer #(
    parameter int NSLOT = 8,
    parameter int NREQ  = 3,
    parameter int IDW   = 2,
    parameter int SW    = 3,
    parameter logic [NSLOT*8-1:0] SLOT_TABLE = '0
) (
    input  logic           clk,
    input  logic           rst_n,
    output logic [SW-1:0]  slot_o,
    output logic [IDW-1:0] owner_o,
    output logic           owner_ok_o
);

    logic [SW-1:0] slot_q;
    logic [7:0]    entry;

    // Advance the slot counter, wrapping at the end of the table.
    always_ff @(posedge clk) begin
        if (!rst_n)
            slot_q <= '0;
        else if (slot_q == SW'(NSLOT - 1))
            slot_q <= '0;
        else
            slot_q <= slot_q + SW'(1);
    end

    // Look up the table entry of the current slot.
    always_comb begin
        entry = SLOT_TABLE[slot_q*8 +: 8];
    end

    assign slot_o     = slot_q;
    assign owner_o    = entry[IDW-1:0];
    assign owner_ok_o = (int'(entry) < NREQ);

    // R2: slot steps by one
    assert_slot_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q != SW'(NSLOT - 1)) |=> (slot_q == $past(slot_q) + SW'(1)));

    // R2: slot wraps to zero
    assert_slot_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q == SW'(NSLOT - 1)) |=> (slot_q == '0));

endmodule

// File: rtl/bank_timer.sv
`timescale 1ns/1ps
// bank_timer
// One down-counter per bank. A select loads BUSY_CLKS-1; the bank reports
// busy while its count is non-zero, so it can be selected again exactly
// BUSY_CLKS clocks after the previous select. Assumes: at most one select per cycle.
module bank_timer #(
    parameter int NBANK     = 8,
    parameter int BUSY_CLKS = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBANK-1:0] sel_i,
    output logic [NBANK-1:0] busy_o
);

    localparam int CW = $clog2(BUSY_CLKS + 1);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [CW-1:0] cnt_q;

        // Load on select, otherwise count down to zero.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt_q <= '0;
            else if (sel_i[b])
                cnt_q <= CW'(BUSY_CLKS - 1);
            else if (cnt_q != '0)
                cnt_q <= cnt_q - CW'(1);
        end

        assign busy_o[b] = (cnt_q != '0);

        // R5: a bank is only selected when idle
        assert_sel_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
            sel_i[b] |-> !busy_o[b]);

        // R5: a select makes the bank busy on the next clock
        assert_busy_after_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
            sel_i[b] |=> busy_o[b]);
    end

endmodule

// File: rtl/write_interlock.sv
`timescale 1ns/1ps
// write_interlock
// Holds, per bank, the address of the last write and a completion counter
// (WR_CLKS clocks from select). Flags a query as blocked when it is a read of
// that exact address, or any write to that bank, before completion.
// Assumes: WR_CLKS >= the bank busy time, so one record per bank is enough.
module write_interlock #(
    parameter int NBANK   = 8,
    parameter int BBITS   = 3,
    parameter int AW      = 12,
    parameter int WR_CLKS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_en_i,
    input  logic             upd_write_i,
    input  logic [BBITS-1:0] upd_bank_i,
    input  logic [AW-1:0]    upd_addr_i,
    input  logic             q_write_i,
    input  logic [BBITS-1:0] q_bank_i,
    input  logic [AW-1:0]    q_addr_i,
    output logic             blocked_o
);

    localparam int WCW = $clog2(WR_CLKS + 1);

    logic [WCW-1:0] wcnt_q  [NBANK];
    logic [AW-1:0]  waddr_q [NBANK];
    logic [NBANK-1:0] pend;

    for (genvar b = 0; b < NBANK; b++) begin : g_rec
        // Record a granted write to this bank and count to its completion.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wcnt_q[b]  <= '0;
                waddr_q[b] <= '0;
            end else if (upd_en_i && upd_write_i && (upd_bank_i == BBITS'(b))) begin
                wcnt_q[b]  <= WCW'(WR_CLKS - 1);
                waddr_q[b] <= upd_addr_i;
            end else if (wcnt_q[b] != '0) begin
                wcnt_q[b]  <= wcnt_q[b] - WCW'(1);
            end
        end
        assign pend[b] = (wcnt_q[b] != '0);
    end

    // Decide whether the queried access must wait for a write to finish.
    always_comb begin
        blocked_o = 1'b0;
        for (int b = 0; b < NBANK; b++) begin
            if (q_bank_i == BBITS'(b) && pend[b]) begin
                if (q_write_i)
                    blocked_o = 1'b1;
                else if (waddr_q[b] == q_addr_i)
                    blocked_o = 1'b1;
            end
        end
    end

    // R8: a write is only issued to a bank with no write in progress
    assert_no_write_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en_i && upd_write_i) |-> !pend[upd_bank_i]);

    // R7: a read never passes an unfinished write to the same address
    assert_no_read_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en_i && !upd_write_i && pend[upd_bank_i]) |-> (waddr_q[upd_bank_i] != upd_addr_i));

endmodule

// File: rtl/slot_bus_arbiter.sv
`timescale 1ns/1ps
// slot_bus_arbiter
// Shares one memory address bus by a fixed slot schedule. In each clock the
// owner of the current slot may issue one access. It is issued when its bank
// timer has expired and no unfinished write interlocks it; otherwise ready
// stays low and the owner retries in its next slot. Unused slots are not lent.
// Assumes: requesters hold valid/write/address steady until ready is seen.
module slot_bus_arbiter
    import slot_arb_pkg::*;
#(
    parameter int NREQ      = 3,
    parameter int NBANK     = 8,
    parameter int AW        = 12,
    parameter int NSLOT     = 8,
    parameter int BUSY_CLKS = 12,
    parameter int WR_CLKS   = 16,
    parameter logic [NSLOT*8-1:0] SLOT_TABLE =
        {8'd2, 8'd1, 8'd0, 8'd1, 8'd0, 8'd2, 8'd1, 8'd0}
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NREQ-1:0]      req_valid,
    input  logic [NREQ-1:0]      req_write,
    input  logic [NREQ*AW-1:0]   req_addr,
    output logic [NREQ-1:0]      req_ready,
    output logic [NBANK-1:0]     bank_sel,
    output logic [AW-1:0]        mem_addr,
    output logic                 mem_write,
    output logic [idx_bits(NREQ)-1:0] mem_owner
);

    localparam int IDW   = idx_bits(NREQ);
    localparam int BBITS = idx_bits(NBANK);
    localparam int SW    = idx_bits(NSLOT);

    logic [SW-1:0]    slot;
    logic [IDW-1:0]   owner;
    logic             owner_ok;
    logic [NBANK-1:0] busy;
    logic             wr_block;

    logic             cand_valid;
    logic             cand_write;
    logic [AW-1:0]    cand_addr;
    logic [BBITS-1:0] cand_bank;
    slot_outcome_e    outcome;
    logic             grant;

    slot_sequencer #(
        .NSLOT(NSLOT), .NREQ(NREQ), .IDW(IDW), .SW(SW), .SLOT_TABLE(SLOT_TABLE)
    ) i_seq (
        .clk(clk), .rst_n(rst_n),
        .slot_o(slot), .owner_o(owner), .owner_ok_o(owner_ok)
    );

    bank_timer #(
        .NBANK(NBANK), .BUSY_CLKS(BUSY_CLKS)
    ) i_timer (
        .clk(clk), .rst_n(rst_n), .sel_i(bank_sel), .busy_o(busy)
    );

    write_interlock #(
        .NBANK(NBANK), .BBITS(BBITS), .AW(AW), .WR_CLKS(WR_CLKS)
    ) i_wlock (
        .clk(clk), .rst_n(rst_n),
        .upd_en_i(grant), .upd_write_i(cand_write),
        .upd_bank_i(cand_bank), .upd_addr_i(cand_addr),
        .q_write_i(cand_write), .q_bank_i(cand_bank), .q_addr_i(cand_addr),
        .blocked_o(wr_block)
    );

    // Pick the request of the current slot owner.
    always_comb begin
        cand_valid = 1'b0;
        cand_write = 1'b0;
        cand_addr  = '0;
        for (int r = 0; r < NREQ; r++) begin
            if (owner_ok && owner == IDW'(r)) begin
                cand_valid = req_valid[r];
                cand_write = req_write[r];
                cand_addr  = req_addr[r*AW +: AW];
            end
        end
        cand_bank = cand_addr[AW-1 -: BBITS];
    end

    // Classify the slot: idle, refused (bank or write interlock) or granted.
    always_comb begin
        if (!cand_valid)
            outcome = SLOT_IDLE;
        else if (busy[cand_bank])
            outcome = SLOT_BUSY;
        else if (wr_block)
            outcome = SLOT_WRHOLD;
        else
            outcome = SLOT_GRANT;
        grant = (outcome == SLOT_GRANT);
    end

    // Drive ready, the bank strobe and the bus fields for a granted slot.
    always_comb begin
        req_ready = '0;
        bank_sel  = '0;
        mem_addr  = '0;
        mem_write = 1'b0;
        mem_owner = '0;
        if (grant) begin
            for (int r = 0; r < NREQ; r++)
                if (owner == IDW'(r)) req_ready[r] = 1'b1;
            for (int b = 0; b < NBANK; b++)
                if (cand_bank == BBITS'(b)) bank_sel[b] = 1'b1;
            mem_addr  = cand_addr;
            mem_write = cand_write;
            mem_owner = owner;
        end
    end

    // R3: never more than one bank strobe
    assert_sel_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_sel));

    // R3: a strobe always comes with exactly one ready
    assert_sel_with_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_sel != '0) |-> ($countones(req_ready) == 1));

    // R2: ready only for the slot owner
    assert_ready_owner_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready != '0) |-> (owner_ok && req_ready[owner]));

    // R4: no grant without a valid request from the owner
    assert_no_lend_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready != '0) |-> ((req_ready & req_valid) == req_ready));

endmodule

// File: tb/test_slot_bus_arbiter.sv
`timescale 1ns/1ps
// Bench for slot_bus_arbiter: behavioural reference model (queues, integer
// timers) compared with the ports in every clock.
module test_slot_bus_arbiter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  req_valid = '0;
    logic [2:0]  req_write = '0;
    logic [35:0] req_addr = '0;
    logic [2:0]  req_ready;
    logic [7:0]  bank_sel;
    logic [11:0] mem_addr;
    logic        mem_write;
    logic [1:0]  mem_owner;

    slot_bus_arbiter i_slot_bus_arbiter (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_ready(req_ready), .bank_sel(bank_sel), .mem_addr(mem_addr),
        .mem_write(mem_write), .mem_owner(mem_owner)
    );

    always #10 clk = ~clk;   // 50 MHz

    int checks = 0;
    int fails  = 0;
    int grants_seen = 0;

    // Pending ops per requester: bit 12 = write flag, bits 11:0 = address.
    int unsigned qa [3][$];

    // Reference state.
    int tbl [8] = '{0, 1, 2, 0, 1, 0, 1, 2};
    int busy [8];
    int wp [8];
    int wa [8];
    int slot = 0;
    int unsigned lf = 32'h1234_5678;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int b = 0; b < 8; b++) begin busy[b] = 0; wp[b] = 0; wa[b] = 0; end
        slot = 0;
    endtask

    // One clock: drive at the falling edge, compare 5 ns later, step the model.
    task automatic step();
        int own; int unsigned a; int w; int b;
        bit gr; string tag;
        int exp_ready; int exp_sel;
        for (int r = 0; r < 3; r++) begin
            if (qa[r].size() != 0) begin
                req_valid[r] = 1'b1;
                req_addr[r*12 +: 12] = qa[r][0][11:0];
                req_write[r] = qa[r][0][12];
            end else begin
                req_valid[r] = 1'b0;
                req_addr[r*12 +: 12] = '0;
                req_write[r] = 1'b0;
            end
        end
        #5;
        own = tbl[slot];
        gr = 1'b0; tag = "R4"; a = 0; w = 0; b = 0;
        exp_ready = 0; exp_sel = 0;
        if (qa[own].size() != 0) begin
            a = qa[own][0] & 32'hfff;
            w = int'((qa[own][0] >> 12) & 1);
            b = int'(a >> 9);
            if (busy[b] > 0)                          tag = "R5 R9";
            else if (w == 1 && wp[b] > 0)             tag = "R8 R9";
            else if (w == 0 && wp[b] > 0 && wa[b] == int'(a)) tag = "R7 R9";
            else begin gr = 1'b1; tag = "R2"; end
        end
        if (gr) begin exp_ready = 1 << own; exp_sel = 1 << b; end
        chk(int'(req_ready) == exp_ready, tag, "req_ready", int'(req_ready), exp_ready);
        chk(int'(bank_sel) == exp_sel, gr ? "R3" : tag, "bank_sel", int'(bank_sel), exp_sel);
        if (gr) begin
            chk(mem_addr == a[11:0], "R3", "mem_addr", int'(mem_addr), int'(a));
            chk(int'(mem_write) == w, "R3", "mem_write", int'(mem_write), w);
            chk(int'(mem_owner) == own, "R3", "mem_owner", int'(mem_owner), own);
        end
        if (req_ready != '0) grants_seen++;
        for (int k = 0; k < 8; k++) begin
            if (busy[k] > 0) busy[k]--;
            if (wp[k] > 0) wp[k]--;
        end
        if (gr) begin
            busy[b] = 11;
            if (w == 1) begin wp[b] = 15; wa[b] = int'(a); end
            void'(qa[own].pop_front());
        end
        slot = (slot + 1) % 8;
        @(negedge clk);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    function automatic int unsigned op(input int wr, input int bank, input int off);
        return (32'(wr) << 12) | (32'(bank) << 9) | 32'(off);
    endfunction

    initial begin
        int g0;
        model_reset();
        repeat (3) @(negedge clk);
        #5;
        // R1: outputs quiet during reset
        chk(req_ready == '0, "R1", "ready in reset", int'(req_ready), 0);
        chk(bank_sel == '0, "R1", "bank_sel in reset", int'(bank_sel), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R6 and R1: three requesters, three idle banks, granted in slots 0..2
        qa[0].push_back(op(0, 0, 'h10));
        qa[1].push_back(op(1, 1, 'h20));
        qa[2].push_back(op(0, 2, 'h30));
        g0 = grants_seen;
        run(3);
        chk(grants_seen - g0 == 3, "R6", "grants in first 3 slots", grants_seen - g0, 3);
        run(13);

        // R5 R9: two requesters to the same bank
        qa[0].push_back(op(0, 3, 'h00));
        qa[1].push_back(op(0, 3, 'h08));
        run(30);

        // R7: write then read of the same address, plus another address in the bank
        qa[0].push_back(op(1, 4, 'h40));
        qa[1].push_back(op(0, 4, 'h40));
        qa[2].push_back(op(0, 4, 'h44));
        run(40);

        // R8: two writes to one bank
        qa[0].push_back(op(1, 5, 'h11));
        qa[2].push_back(op(1, 5, 'h22));
        run(40);

        // R4: one requester only, others idle
        qa[2].push_back(op(0, 6, 'h01));
        run(10);

        // Mixed traffic
        for (int i = 0; i < 400; i++) begin
            for (int r = 0; r < 3; r++) begin
                lf = lf * 32'd1103515245 + 32'd12345;
                if (qa[r].size() < 2 && lf[20:19] == 2'b00)
                    qa[r].push_back(op(int'(lf[16]), int'(lf[10:8]), int'(lf[27:25])));
            end
            step();
        end
        run(60);

        // R1: a mid-run reset clears the timers and the slot
        qa[0].push_back(op(1, 7, 'h05));
        run(1);
        rst_n = 1'b0;
        for (int r = 0; r < 3; r++) qa[r].delete();
        run(2);
        model_reset();
        rst_n = 1'b1;
        qa[0].push_back(op(1, 7, 'h05));
        g0 = grants_seen;
        run(1);
        chk(grants_seen - g0 == 1, "R1", "grant right after reset", grants_seen - g0, 1);
        run(20);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run is a failure.
    initial begin
        #(20 * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule